// File: doc/BRIEF.md
# Coprocessor Bus-Master Handshake Sequencer

This block lets a coprocessor borrow a host CPU's shared bus to move an operand that spans several memory words. When it receives a start command with a base address, a word count and a direction, it pulls a shared, open-drain request/grant line low for one clock. It then waits, for as long as needed, until the host answers with its own one-clock low grant pulse. Once it owns the bus, it runs one bus cycle for each word. Each bus cycle is a sequence of T-states, and each new cycle uses an address one word higher than the last. At the end it pulls the same line low for one more clock to hand the bus back, and then reports completion.

During each bus cycle the block drives the multiplexed address/status lines with the timing the host's bus controller expects. T1 carries the full address and the upper-byte enable. The other T-states carry the fixed status pattern. The three encoded status lines go active one state before T1 and return to passive once READY allows the cycle to finish. The data path and the status decoder sit outside this block.

Top module: `cbm_bus_master`

## Requirements
- R1: A start with a non-zero word count, accepted while idle, makes `rqgt_drive_o` high (the shared line pulled low) for exactly the one cycle that follows the accepting clock edge.
- R2: After the request the block waits without limit for the line to be sampled low. Until the grant is sampled, `rqgt_drive_o` stays 0, `sts_o` stays 3'b111, `bhe_s7_o` stays 1 and the address lines stay 0.
- R3: A grant sampled on a clock edge starts a lead state on the next cycle, followed by T1. In T1, `ad_o` carries address bits 15:0, `ahs_o` carries bits 19:16, and `bhe_s7_o` is 0 (upper byte enabled).
- R4: Exactly one T1 occurs per word. Word i (counting from 0) uses address base + 2*i, modulo 2^20.
- R5: In T2, T3, Tw and T4, `ahs_o` is 4'b1011 (S6=1, S5=0, S4=1, S3=1), `bhe_s7_o` is 1 (S7) and `ad_o` is 0.
- R6: The status code on `sts_o` ({S2,S1,S0}) is 3'b101 for a read and 3'b110 for a write. It is driven in the lead state, in T1, in T2, and in any T4 that is followed by another T1.
- R7: In T3 and Tw, `sts_o` shows the active code while `ready_i` is low and 3'b111 while `ready_i` is high. A low `ready_i` sampled at the end of T3 or Tw adds a Tw. A high `ready_i` leads to T4. The T4 of the last word shows 3'b111.
- R8: The cycle after the last T4 drives `rqgt_drive_o` high for exactly one cycle to release the bus.
- R9: `done_o` is 1 for exactly the one cycle that follows the release cycle.
- R10: A start asserted between acceptance and the release cycle is ignored. The address, count and direction of the running transfer do not change.
- R11: A start with a word count of 0 is ignored, and no request is made.
- R12: While the synchronous active-high `rst` is high, and in the first cycle after it falls, all outputs are idle: drive 0, status 3'b111, `bhe_s7_o` 1, address lines 0, `done_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command, sampled each edge |
| base_addr_i | input | 20 | First word address |
| word_count_i | input | 8 | Number of words to move |
| write_i | input | 1 | 1 = memory write, 0 = memory read |
| rqgt_i | input | 1 | Sampled level of the shared request/grant line (low = pulse) |
| ready_i | input | 1 | Bus READY |
| rqgt_drive_o | output | 1 | 1 = pull the shared line low this cycle |
| ad_o | output | 16 | Low address bits (valid in T1) |
| ahs_o | output | 4 | Address 19:16 in T1, S6..S3 otherwise |
| sts_o | output | 3 | Encoded bus status {S2,S1,S0} |
| bhe_s7_o | output | 1 | Upper-byte enable (active low) in T1, S7 otherwise |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
- **Request:** The request appears in the cycle right after the edge that samples start.
- **Grant to T1:** A grant sampled at an edge gives the lead state in the next cycle and T1 in the cycle after that.
- **Cycle length:** T2 follows T1. T3 follows T2. Each low READY sampled at the end of T3 or Tw adds exactly one Tw before T4.
- **Release and done:** The release pulse falls in the cycle after the last T4, and done in the cycle after that.

The bench changes inputs just after a rising edge and samples outputs at the falling edge. It walks each transfer one state at a time with these counts, so every check lands in the state it names. A monitor compares each T1 it sees against the queue of expected addresses and codes.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_REQ,
    HS_WAIT,
    HS_OWN,
    HS_REL
  } hs_state_t;

  typedef enum logic [2:0] {
    TP_IDLE,
    TP_LEAD,
    TP_T1,
    TP_T2,
    TP_T3,
    TP_TW,
    TP_T4
  } tphase_t;

  localparam logic [2:0] STS_READ    = 3'b101;
  localparam logic [2:0] STS_WRITE   = 3'b110;
  localparam logic [2:0] STS_PASSIVE = 3'b111;

  // {S6,S5,S4,S3} driven on the upper lines outside T1
  localparam logic [3:0] HI_STATUS   = 4'b1011;

endpackage

// File: rtl/cbm_handshake.sv
module cbm_handshake
  import cbm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      cnt_zero_i,
  input  logic      rqgt_i,
  input  logic      xfer_end_i,
  output logic      accept_o,
  output logic      go_o,
  output logic      rq_drive_o,
  output logic      done_o,
  output hs_state_t state_o
);

  hs_state_t st;

  assign accept_o   = (st == HS_IDLE) && start_i && !cnt_zero_i;
  assign go_o       = (st == HS_WAIT) && !rqgt_i;
  assign rq_drive_o = (st == HS_REQ) || (st == HS_REL);
  assign state_o    = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= HS_IDLE;
      done_o <= 1'b0;
    end else begin
      done_o <= (st == HS_REL);
      case (st)
        HS_IDLE: if (accept_o)   st <= HS_REQ;
        HS_REQ:                  st <= HS_WAIT;
        HS_WAIT: if (go_o)       st <= HS_OWN;
        HS_OWN:  if (xfer_end_i) st <= HS_REL;
        HS_REL:                  st <= HS_IDLE;
        default:                 st <= HS_IDLE;
      endcase
    end
  end

  // R1 / R8: every pull on the shared line lasts a single clock
  a_r1_pulse_one_clock: assert property (@(posedge clk) disable iff (rst)
    $rose(rq_drive_o) |=> !rq_drive_o);

  // R9: completion only directly after a release pulse
  a_r9_done_after_release: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(rq_drive_o));

  // R9: completion never lasts longer than one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/cbm_addr_ctr.sv
module cbm_addr_ctr #(
  parameter int AW   = 20,
  parameter int CW   = 8,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          write_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          write_o
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] remain;

  assign last_o = (remain == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      remain  <= '0;
      write_o <= 1'b0;
    end else if (load_i) begin
      addr_o  <= base_i;
      remain  <= count_i;
      write_o <= write_i;
    end else if (step_i) begin
      addr_o  <= addr_o + STEP_V;
      remain  <= remain - ONE;
    end
  end

  // R4: a step is never asked for once the final word is reached
  a_r4_no_step_past_last: assert property (@(posedge clk) disable iff (rst)
    step_i |-> !last_o && (remain != '0));

endmodule

// File: rtl/cbm_tphase.sv
module cbm_tphase
  import cbm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    go_i,
  input  logic    ready_i,
  input  logic    last_i,
  output tphase_t phase_o,
  output logic    step_o,
  output logic    end_o
);

  tphase_t ph;

  assign phase_o = ph;
  assign step_o  = (ph == TP_T4) && !last_i;
  assign end_o   = (ph == TP_T4) && last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= TP_IDLE;
    end else begin
      case (ph)
        TP_IDLE: if (go_i) ph <= TP_LEAD;
        TP_LEAD: ph <= TP_T1;
        TP_T1:   ph <= TP_T2;
        TP_T2:   ph <= TP_T3;
        TP_T3:   ph <= ready_i ? TP_T4 : TP_TW;
        TP_TW:   ph <= ready_i ? TP_T4 : TP_TW;
        TP_T4:   ph <= last_i ? TP_IDLE : TP_T1;
        default: ph <= TP_IDLE;
      endcase
    end
  end

  // R7: a wait state only follows a low READY
  a_r7_wait_needs_low_ready: assert property (@(posedge clk) disable iff (rst)
    (ph == TP_TW) |-> !$past(ready_i));

  // R7: T4 is entered only after READY was seen high
  a_r7_t4_after_ready: assert property (@(posedge clk) disable iff (rst)
    (ph == TP_T4) |-> $past(ready_i));

endmodule

// File: rtl/cbm_bus_master.sv
module cbm_bus_master
  import cbm_pkg::*;
#(
  parameter int AW   = 20,
  parameter int CW   = 8,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] word_count_i,
  input  logic          write_i,
  input  logic          rqgt_i,
  input  logic          ready_i,
  output logic          rqgt_drive_o,
  output logic [AW-5:0] ad_o,
  output logic [3:0]    ahs_o,
  output logic [2:0]    sts_o,
  output logic          bhe_s7_o,
  output logic          done_o
);

  localparam int LW = AW - 4;

  logic          accept, go, xfer_end, step, last, xwrite;
  logic [AW-1:0] addr;
  logic [2:0]    code;
  hs_state_t     hs_state;
  tphase_t       phase;

  cbm_handshake u_hs (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cnt_zero_i (word_count_i == '0),
    .rqgt_i     (rqgt_i),
    .xfer_end_i (xfer_end),
    .accept_o   (accept),
    .go_o       (go),
    .rq_drive_o (rqgt_drive_o),
    .done_o     (done_o),
    .state_o    (hs_state)
  );

  cbm_addr_ctr #(.AW(AW), .CW(CW), .STEP(STEP)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept),
    .base_i  (base_addr_i),
    .count_i (word_count_i),
    .write_i (write_i),
    .step_i  (step),
    .addr_o  (addr),
    .last_o  (last),
    .write_o (xwrite)
  );

  cbm_tphase u_tp (
    .clk     (clk),
    .rst     (rst),
    .go_i    (go),
    .ready_i (ready_i),
    .last_i  (last),
    .phase_o (phase),
    .step_o  (step),
    .end_o   (xfer_end)
  );

  assign code = xwrite ? STS_WRITE : STS_READ;

  always_comb begin
    ad_o     = '0;
    ahs_o    = '0;
    bhe_s7_o = 1'b1;
    sts_o    = STS_PASSIVE;
    case (phase)
      TP_LEAD: sts_o = code;
      TP_T1: begin
        ad_o     = addr[LW-1:0];
        ahs_o    = addr[AW-1:LW];
        bhe_s7_o = 1'b0;
        sts_o    = code;
      end
      TP_T2: begin
        ahs_o = HI_STATUS;
        sts_o = code;
      end
      TP_T3, TP_TW: begin
        ahs_o = HI_STATUS;
        sts_o = ready_i ? STS_PASSIVE : code;
      end
      TP_T4: begin
        ahs_o = HI_STATUS;
        sts_o = last ? STS_PASSIVE : code;
      end
      default: ;
    endcase
  end

  // R2: nothing on the bus while waiting for the grant
  a_r2_quiet_until_grant: assert property (@(posedge clk) disable iff (rst)
    (hs_state == HS_WAIT) |-> (sts_o == STS_PASSIVE) && bhe_s7_o && (ahs_o == 4'd0));

  // R4: the word address is frozen from T2 through the wait states
  a_r4_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (phase == TP_T2 || phase == TP_T3 || phase == TP_TW) |=> $stable(addr));

  // R6: T1 always carries an active code
  a_r6_t1_active: assert property (@(posedge clk) disable iff (rst)
    (phase == TP_T1) |-> (sts_o != STS_PASSIVE));

  // R10: the direction of a running transfer never changes
  a_r10_dir_kept: assert property (@(posedge clk) disable iff (rst)
    (hs_state != HS_IDLE) |=> $stable(xwrite));

endmodule

// File: tb/cbm_bus_master_test.sv
module cbm_bus_master_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [19:0] base = '0;
  logic [7:0]  count = '0;
  logic        wr = 1'b0;
  logic        host_grant = 1'b0;
  logic        ready = 1'b1;
  logic        rqgt_line;
  logic        drive;
  logic [15:0] ad;
  logic [3:0]  ahs;
  logic [2:0]  sts;
  logic        bhe;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [22:0] expq[$];

  always #5 clk = ~clk;

  assign rqgt_line = (host_grant || drive) ? 1'b0 : 1'b1;

  cbm_bus_master uut (
    .clk(clk), .rst(rst), .start_i(start), .base_addr_i(base),
    .word_count_i(count), .write_i(wr), .rqgt_i(rqgt_line), .ready_i(ready),
    .rqgt_drive_o(drive), .ad_o(ad), .ahs_o(ahs), .sts_o(sts),
    .bhe_s7_o(bhe), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: every T1 (upper-byte enable low) is compared with the queue
  always @(negedge clk) begin
    if (!rst && bhe == 1'b0) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected T1", {9'd0, sts, ahs, ad}, 32'd0);
      end else begin
        logic [22:0] e;
        e = expq.pop_front();
        chk({sts, ahs, ad} == e, "R3/R4/R6 T1 address+code",
            {9'd0, sts, ahs, ad}, {9'd0, e});
      end
    end
  end

  task automatic idle_check(input string req);
    chk(drive == 1'b0 && sts == 3'b111 && bhe == 1'b1 && ahs == 4'd0 && ad == 16'd0,
        req, {drive, sts, bhe, ahs, ad}, {1'b0, 3'b111, 1'b1, 20'd0});
  endtask

  task automatic xfer(input logic [19:0] b, input logic [7:0] n, input bit w,
                      input int ws, input int gwait);
    logic [2:0] code;
    code = w ? 3'b110 : 3'b101;
    @(posedge clk); #1;
    start = 1'b1; base = b; count = n; wr = w;
    for (int i = 0; i < n; i++) expq.push_back({code, b + 20'(2 * i)});
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(drive == 1'b1, "R1 request pulse", {31'd0, drive}, 32'd1);
    for (int k = 0; k < gwait; k++) begin
      @(posedge clk); #1;
      if (k == 0) begin
        start = 1'b1; base = 20'h12340; count = 8'd5; wr = ~w;  // R10 stray start
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      idle_check("R2/R10 no bus before grant");
    end
    @(posedge clk); #1;
    start = 1'b0;
    host_grant = 1'b1;
    @(posedge clk); #1;
    host_grant = 1'b0;
    @(negedge clk);
    chk(sts == code, "R6 lead state code", {29'd0, sts}, {29'd0, code});
    for (int wd = 0; wd < n; wd++) begin
      @(posedge clk); #1;                       // T1
      @(negedge clk);
      chk(bhe == 1'b0, "R3 T1 enable", {31'd0, bhe}, 32'd0);
      @(posedge clk); #1;                       // T2
      @(negedge clk);
      chk(ahs == 4'b1011 && bhe == 1'b1 && ad == 16'd0 && sts == code,
          "R5/R6 T2 lines", {8'd0, ahs, bhe, sts, ad}, {8'd0, 4'b1011, 1'b1, code, 16'd0});
      @(posedge clk); #1;                       // T3
      ready = (ws == 0);
      @(negedge clk);
      chk(sts == ((ws == 0) ? 3'b111 : code), "R7 T3 status",
          {29'd0, sts}, {29'd0, (ws == 0) ? 3'b111 : code});
      for (int k = 1; k <= ws; k++) begin     // Tw
        @(posedge clk); #1;
        ready = (k == ws);
        @(negedge clk);
        chk(sts == ((k == ws) ? 3'b111 : code) && ahs == 4'b1011,
            "R7/R5 Tw status", {25'd0, ahs, sts}, {25'd0, 4'b1011, (k == ws) ? 3'b111 : code});
      end
      @(posedge clk); #1;                       // T4
      ready = 1'b1;
      @(negedge clk);
      chk(sts == ((wd == n - 1) ? 3'b111 : code) && ahs == 4'b1011 && drive == 1'b0,
          "R6/R7 T4 status", {24'd0, drive, ahs, sts},
          {24'd0, 1'b0, 4'b1011, (wd == n - 1) ? 3'b111 : code});
    end
    @(posedge clk); #1;
    @(negedge clk);
    chk(drive == 1'b1 && done == 1'b0, "R8 release pulse", {30'd0, drive, done}, 32'd2);
    @(posedge clk); #1;
    @(negedge clk);
    chk(done == 1'b1 && drive == 1'b0, "R9 done pulse", {30'd0, drive, done}, 32'd1);
    @(posedge clk); #1;
    @(negedge clk);
    chk(done == 1'b0, "R9 done single", {31'd0, done}, 32'd0);
    idle_check("R10 no follow-on request");
    chk(expq.size() == 0, "R4 all words seen", expq.size(), 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_check("R12 outputs in reset");
    chk(done == 1'b0, "R12 done in reset", {31'd0, done}, 32'd0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    idle_check("R12 idle after reset");

    xfer(20'h01000, 8'd3, 1'b0, 0, 3);
    xfer(20'h0A0F0, 8'd2, 1'b1, 2, 5);
    xfer(20'hFFFFE, 8'd2, 1'b0, 1, 2);   // R4 wrap past top of space
    xfer(20'h00010, 8'd1, 1'b1, 0, 40);  // R2 long grant wait

    // R11: zero-length start
    @(posedge clk); #1;
    start = 1'b1; base = 20'h00200; count = 8'd0; wr = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      idle_check("R11 zero count ignored");
      @(posedge clk); #1;
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule